// File: doc/BRIEF.md
# Peripheral Interrupt Routing Mapper

This block sits between a set of peripheral interrupt request lines and the nine general-purpose priority inputs of a core event controller. These inputs are the levels numbered 7 through 15. Each source has three controls: a mask bit that lets its request through or blocks it, a status bit that shows whether the source is raising a request, and a 4-bit assignment field that picks which level the source drives. Several sources may share one level. When they do, software reads the status register to find out which source raised the shared level. The mapper does no prioritising between levels; that is left to the controller downstream.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational from the stored state. The request inputs are captured into the status register on every clock. The level outputs are formed from that captured state, so a level follows its sources one cycle later.

Top module: `irq_route_map`

## Requirements
- R1: While reset is held, and on the first read after it is released, the mask register reads 0, the status register reads 0 and all nine level outputs are 0.
- R2: The status register sits at address 1. Each clock it captures the raw request inputs, bit s for source s, whatever the mask holds. Writes to it change nothing.
- R3: The mask register sits at address 0 and is read/write. A mask bit of 1 passes its source; a mask bit of 0 blocks it.
- R4: The assignment registers sit at addresses 2 to 5. The register at address 2+k holds the fields of sources 8k to 8k+7. The field of source s sits in bits [4*(s mod 8)+3 : 4*(s mod 8)]. Each register reads back what was written to it.
- R5: Output bit L (L = 0..8, for controller level L+7) is the OR of every source whose captured status is 1, whose mask bit is 1 and whose field equals L. It reflects input changes one clock later.
- R6: A field value from 9 to 15 routes its source to no output, even when the source is unmasked and asserting.
- R7: Any number of sources may carry the same field value. Their level is then set while any one of them is active and unmasked.
- R8: Writes to addresses 6 and 7 change no register. Reads of those addresses return 0.
- R9: After reset, the field of source s holds s mod 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 32 | Peripheral request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lvl_req_o | output | 9 | Level requests; bit 0 is level 7, bit 8 is level 15 |

## Verification
The bench targets the following corner cases:
- Several sources share a level, and the bench drops them one at a time. A design that kept only the last matching source would lose the level too early.
- Fields of 9 to 15 are programmed on sources that are asserting. A design that wrapped or truncated the field would drive a real level.
- A source is masked while it is asserting. The bench checks that the status still shows it; a design that gated the status with the mask would hide it.
- Writes go to the status address and the unused addresses. A decoder that aliased them would corrupt the mask or the assignment registers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int FIELD_W  = 4;
  localparam int REG_W    = 32;
  localparam int FLD_PER_REG = REG_W / FIELD_W;

  // Register addresses
  localparam logic [2:0] ADDR_MASK   = 3'd0;
  localparam logic [2:0] ADDR_STATUS = 3'd1;
  localparam logic [2:0] ADDR_ASN0   = 3'd2;

  // True when a field selects output level index lvl
  function automatic logic field_hits(input logic [FIELD_W-1:0] fld, input int lvl);
    return (int'(fld) == lvl);
  endfunction

  // Which assignment register holds source s
  function automatic int asn_reg_of(input int s);
    return s / FLD_PER_REG;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_ASN = 4,
  parameter logic [NUM_SRC*FIELD_W-1:0] DEFAULT_MAP = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [NUM_SRC-1:0]         mask_q,
  output logic [NUM_SRC*FIELD_W-1:0] asn_q
);
  wire wr_mask = reg_we && (reg_addr == ADDR_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
  end

  // One storage slice per assignment register
  for (genvar k = 0; k < NUM_ASN; k++) begin : g_asn
    localparam logic [2:0] MY_ADDR = ADDR_ASN0 + 3'(k);
    wire wr_this = reg_we && (reg_addr == MY_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) asn_q[k*REG_W +: REG_W] <= DEFAULT_MAP[k*REG_W +: REG_W];
      else if (wr_this) asn_q[k*REG_W +: REG_W] <= reg_wdata;
    end
  end
endmodule

// File: rtl/irq_level_or.sv
module irq_level_or
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 9
) (
  input  logic [NUM_SRC-1:0]         active,
  input  logic [NUM_SRC*FIELD_W-1:0] asn,
  output logic [NUM_LVL-1:0]         lvl
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    always_comb begin
      lvl[l] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (active[s] && field_hits(asn[s*FIELD_W +: FIELD_W], l)) lvl[l] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 9,
  parameter logic [NUM_SRC*FIELD_W-1:0] DEFAULT_MAP =
    128'h43210_876543210_876543210_876543210
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [NUM_LVL-1:0] lvl_req_o
);
  localparam int NUM_ASN = (NUM_SRC * FIELD_W) / REG_W;

  logic [NUM_SRC-1:0]         status_q;
  logic [NUM_SRC-1:0]         mask_q;
  logic [NUM_SRC*FIELD_W-1:0] asn_q;
  logic [NUM_SRC-1:0]         active_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= irq_req_i;
  end

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_ASN(NUM_ASN), .DEFAULT_MAP(DEFAULT_MAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mask_q(mask_q), .asn_q(asn_q)
  );

  assign active_src = status_q & mask_q;

  irq_level_or #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_or (
    .active(active_src), .asn(asn_q), .lvl(lvl_req_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_MASK)        reg_rdata[NUM_SRC-1:0] = mask_q;
    else if (reg_addr == ADDR_STATUS) reg_rdata[NUM_SRC-1:0] = status_q;
    else begin
      for (int k = 0; k < NUM_ASN; k++)
        if (reg_addr == ADDR_ASN0 + 3'(k)) reg_rdata = asn_q[k*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/irq_route_map_chk.sv
module irq_route_map_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_req_i,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] active_src,
  input logic               reg_we,
  input logic [2:0]         reg_addr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [NUM_LVL-1:0] lvl_req_o
);
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  a_r2_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> status_q == $past(irq_req_i));

  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_MASK) |=> mask_q == $past(reg_wdata[NUM_SRC-1:0]));

  a_r5_level_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_req_o) |-> (|(status_q & mask_q)));

  a_r5_level_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_req_o) <= $countones(active_src));

  a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != ADDR_MASK) |=> $stable(mask_q));
endmodule

bind irq_route_map irq_route_map_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .status_q(status_q),
  .mask_q(mask_q), .active_src(active_src), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .lvl_req_o(lvl_req_o)
);

// File: tb/irq_route_map_bench.sv
`timescale 1ns/1ps
module irq_route_map_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_req_i = '0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  lvl_req_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_mask;
  logic [3:0]  m_fld [32];

  always #10 clk = ~clk;

  irq_route_map u_irq_route_map (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_req_o(lvl_req_o)
  );

  function automatic logic [8:0] exp_lvl(input logic [31:0] req);
    logic [8:0] r = '0;
    for (int s = 0; s < 32; s++)
      if (req[s] && m_mask[s] && m_fld[s] < 4'd9) r[m_fld[s]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_asn(input int k);
    logic [31:0] r;
    for (int j = 0; j < 8; j++) r[4*j +: 4] = m_fld[8*k + j];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 3'd0) m_mask = d;
    else if (a >= 3'd2 && a <= 3'd5)
      for (int j = 0; j < 8; j++) m_fld[8*(int'(a)-2) + j] = d[4*j +: 4];
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic drive_irq(input logic [31:0] v, input string req);
    logic [31:0] st;
    @(negedge clk); irq_req_i = v;
    @(negedge clk);
    check(req, {23'd0, lvl_req_o}, {23'd0, exp_lvl(v)});
    rd(3'd1, st);
    check("R2 status", st, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7331));
    m_mask = '0;
    for (int s = 0; s < 32; s++) m_fld[s] = 4'(s % 9);   // R9 default
    repeat (3) @(negedge clk);
    check("R1 level out in reset", {23'd0, lvl_req_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, d); check("R1 mask reset", d, 32'd0);
    rd(3'd1, d); check("R1 status reset", d, 32'd0);
    check("R1 level out", {23'd0, lvl_req_o}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k + 2), d); check("R9 default map", d, exp_asn(k));
    end
    // R3: masked sources stay quiet, but status still shows them (R2)
    drive_irq(32'hFFFF_FFFF, "R3 all masked");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R3 mask readback", d, 32'hFFFF_FFFF);
    drive_irq(32'h0000_0001, "R5 single source");
    // R7: sources 0, 9, 18, 27 share level 7 by default
    drive_irq(32'h0804_0201, "R7 shared all");
    drive_irq(32'h0804_0200, "R7 shared drop one");
    drive_irq(32'h0800_0000, "R7 shared last");
    // R6: dead fields 9..15
    wr(3'd2, 32'hFEDC_BA9F);
    rd(3'd2, d); check("R4 asn readback", d, 32'hFEDC_BA9F);
    drive_irq(32'h0000_00FF, "R6 dead fields");
    // R4: field placement, source 13 -> level 15 (field 8) in reg at addr 3
    wr(3'd3, 32'h0080_0000);
    drive_irq(32'h0000_2000, "R4 source 13 placement");
    // R8: writes to status and unused addresses
    wr(3'd1, 32'h1234_5678);
    wr(3'd6, 32'hDEAD_BEEF);
    wr(3'd7, 32'hCAFE_F00D);
    rd(3'd0, d); check("R8 mask unchanged", d, m_mask);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k + 2), d); check("R8 asn unchanged", d, exp_asn(k));
    end
    rd(3'd6, d); check("R8 unused read", d, 32'd0);
    rd(3'd7, d); check("R8 unused read", d, 32'd0);
    drive_irq(32'h0000_2000, "R8 level after stray writes");
    // Random mix (R5)
    for (int i = 0; i < 300; i++) begin
      int c = $urandom_range(0, 3);
      if (c == 0) wr(3'd0, $urandom());
      else if (c == 1) wr(3'($urandom_range(2, 5)), $urandom());
      drive_irq($urandom() & $urandom(), "R5 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule